// File: doc/BRIEF.md
# DSP Load/Store Address Generator

This block computes the effective address and the updated base-register value for the load, store and address-arithmetic operations of a DSP data path. Each request carries a base register value and its register index, the register side it belongs to, an offset, an access size and a modify form. The offset is either a register value or a 5-bit unsigned immediate. It is scaled by the access size and then added to or subtracted from the base, before or after the access, or with no write-back at all. Address-add and address-subtract operations use exactly the same calculation, so the instruction decoder routes them through this block as well.

On each of the two register sides, base registers 4 to 7 can be set to wrap circularly. A 16-bit mode configuration word holds one 2-bit field per eligible register. A field either selects linear addressing or selects one of two block-size settings. In circular mode only the low address bits wrap, modulo the block size, and the upper bits come from the base. The result is registered and appears one cycle after the request, qualified by a valid strobe.

Top module: `dsp_agu`

## Requirements
- R1: With `off_sel_i`=1 the offset is the full 32-bit `off_reg_i`. With `off_sel_i`=0 it is `off_imm_i` zero-extended to 32 bits.
- R2: The offset is shifted left by `size_i` before use: 0 for byte, 1 for half-word, 2 for word, 3 for double-word. The result is truncated to 32 bits.
- R3: Modify codes 0 (positive offset) and 1 (negative offset) give `addr_o` = base plus or minus the scaled offset, `base_new_o` = base, and `wb_en_o`=0. Codes 6 and 7 behave like code 0.
- R4: Modify codes 2 (pre-increment) and 3 (pre-decrement) give `addr_o` = `base_new_o` = the updated address, with `wb_en_o`=1.
- R5: Modify codes 4 (post-increment) and 5 (post-decrement) give `addr_o` = base, `base_new_o` = the updated address, and `wb_en_o`=1.
- R6: Only base indices 4 to 7 can use circular addressing. Every other index uses linear 32-bit arithmetic whatever the configuration holds.
- R7: The 2-bit mode field for side s and index i (4..7) sits at `cfg_mode_i[2*(4*s+i-4) +: 2]`. The codes are: 00 linear, 01 circular with `cfg_bk0_i`, 10 circular with `cfg_bk1_i`, and 11 linear.
- R8: In circular mode with block-size value N, the block is 2^(N+1) bytes. Address bits at and above N+1 are taken from the base, and the lower bits wrap modulo the block. With N=31 the whole 32-bit space wraps.
- R9: Results appear one clock after a request. `valid_o` equals `req_i` delayed by one cycle, and `wb_en_o` is 0 whenever `valid_o` is 0.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| side_i | input | 1 | Register side of the base (0 or 1) |
| base_idx_i | input | 4 | Base register index |
| base_i | input | 32 | Base register value |
| off_sel_i | input | 1 | 1 selects register offset, 0 selects immediate |
| off_reg_i | input | 32 | Register offset |
| off_imm_i | input | 5 | Unsigned immediate offset |
| size_i | input | 2 | Access size / scaling shift |
| mod_i | input | 3 | Modify form code |
| cfg_mode_i | input | 16 | Per-register addressing mode fields |
| cfg_bk0_i | input | 5 | Block-size value 0 |
| cfg_bk1_i | input | 5 | Block-size value 1 |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective address |
| base_new_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Base write-back enable |

## Verification
The assertions check the properties that must hold on every cycle, whatever the arithmetic produces:
- the valid strobe follows the request by one cycle;
- write-back occurs only with a valid result;
- the offset forms never write back and keep the base;
- the pre forms access the value they write back;
- the post forms access the original base.

Only the bench scenarios can show the arithmetic itself. This covers:
- offset source and scaling;
- eligibility of the circular registers and which mode field each one reads;
- wraparound at both edges of a block, for both block-size selections;
- the full-range block size.

The bench compares these results against an independent modulo-based model.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_LIN   = 2'b00,
    AM_CIRC0 = 2'b01,
    AM_CIRC1 = 2'b10,
    AM_RSVD  = 2'b11
  } am_e;

  localparam logic [2:0] MOD_POS   = 3'd0;
  localparam logic [2:0] MOD_NEG   = 3'd1;
  localparam logic [2:0] MOD_PREI  = 3'd2;
  localparam logic [2:0] MOD_PRED  = 3'd3;
  localparam logic [2:0] MOD_POSTI = 3'd4;
  localparam logic [2:0] MOD_POSTD = 3'd5;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 5
) (
  input  logic             sel_i,
  input  logic [AW-1:0]    reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       size_i,
  output logic [AW-1:0]    off_o
);
  logic [AW-1:0] raw;

  always_comb begin
    raw = sel_i ? reg_i : AW'(imm_i);
    unique case (size_i)
      2'd0:    off_o = raw;
      2'd1:    off_o = raw << 1;
      2'd2:    off_o = raw << 2;
      default: off_o = raw << 3;
    endcase
  end
endmodule

// File: rtl/agu_mode_lookup.sv
module agu_mode_lookup
  import agu_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned SIDES   = 2,
  parameter int unsigned CIRC_LO = 4,
  parameter int unsigned CIRC_N  = 4,
  parameter int unsigned BK_W    = 5,
  localparam int unsigned SIDE_W = (SIDES > 1) ? $clog2(SIDES) : 1,
  localparam int unsigned NREG   = SIDES * CIRC_N,
  localparam int unsigned MODE_W = 2 * NREG
) (
  input  logic [SIDE_W-1:0] side_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [BK_W-1:0]   bk0_i,
  input  logic [BK_W-1:0]   bk1_i,
  output logic              circ_o,
  output logic [AW-1:0]     mask_o
);
  logic [NREG-1:0] hit;
  logic [1:0]      fld_v [NREG];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    for (genvar r = 0; r < CIRC_N; r++) begin : g_reg
      localparam int unsigned K = s * CIRC_N + r;
      assign hit[K]   = (side_i == SIDE_W'(s)) && (idx_i == IDX_W'(CIRC_LO + r));
      assign fld_v[K] = hit[K] ? cfg_mode_i[2*K +: 2] : 2'b00;
    end
  end

  am_e             mode;
  logic [BK_W-1:0] bk;

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int k = 0; k < int'(NREG); k++) acc = acc | fld_v[k];
    mode   = am_e'(acc);
    circ_o = (mode == AM_CIRC0) || (mode == AM_CIRC1);
    bk     = (mode == AM_CIRC1) ? bk1_i : bk0_i;
    if (32'(bk) + 32'd1 >= 32'(AW)) mask_o = '1;
    else                            mask_o = (AW'(1) << (32'(bk) + 32'd1)) - AW'(1);
  end
endmodule

// File: rtl/agu_update.sv
module agu_update
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  input  logic [2:0]    mod_i,
  input  logic          circ_i,
  input  logic [AW-1:0] mask_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] base_new_o,
  output logic          wb_o
);
  logic          dec;
  logic [AW-1:0] sum, upd;

  always_comb begin
    dec = (mod_i == MOD_NEG) || (mod_i == MOD_PRED) || (mod_i == MOD_POSTD);
    sum = dec ? (base_i - off_i) : (base_i + off_i);
    // circular: keep upper bits, wrap lower bits inside the block
    upd = circ_i ? ((base_i & ~mask_i) | (sum & mask_i)) : sum;
    unique case (mod_i)
      MOD_PREI, MOD_PRED: begin
        addr_o = upd; base_new_o = upd; wb_o = 1'b1;
      end
      MOD_POSTI, MOD_POSTD: begin
        addr_o = base_i; base_new_o = upd; wb_o = 1'b1;
      end
      default: begin
        addr_o = upd; base_new_o = base_i; wb_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int unsigned AW      = 32,
  parameter int unsigned IMM_W   = 5,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned SIDES   = 2,
  parameter int unsigned CIRC_LO = 4,
  parameter int unsigned CIRC_N  = 4,
  parameter int unsigned BK_W    = 5,
  localparam int unsigned SIDE_W = (SIDES > 1) ? $clog2(SIDES) : 1,
  localparam int unsigned MODE_W = 2 * SIDES * CIRC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [SIDE_W-1:0] side_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [AW-1:0]     base_i,
  input  logic              off_sel_i,
  input  logic [AW-1:0]     off_reg_i,
  input  logic [IMM_W-1:0]  off_imm_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        mod_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [BK_W-1:0]   cfg_bk0_i,
  input  logic [BK_W-1:0]   cfg_bk1_i,
  output logic              valid_o,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     base_new_o,
  output logic              wb_en_o
);
  logic [AW-1:0] off_s, mask, addr_d, base_d;
  logic          circ, wb_d;

  agu_offset #(.AW(AW), .IMM_W(IMM_W)) i_offset (
    .sel_i (off_sel_i),
    .reg_i (off_reg_i),
    .imm_i (off_imm_i),
    .size_i(size_i),
    .off_o (off_s)
  );

  agu_mode_lookup #(
    .AW(AW), .IDX_W(IDX_W), .SIDES(SIDES),
    .CIRC_LO(CIRC_LO), .CIRC_N(CIRC_N), .BK_W(BK_W)
  ) i_lookup (
    .side_i    (side_i),
    .idx_i     (base_idx_i),
    .cfg_mode_i(cfg_mode_i),
    .bk0_i     (cfg_bk0_i),
    .bk1_i     (cfg_bk1_i),
    .circ_o    (circ),
    .mask_o    (mask)
  );

  agu_update #(.AW(AW)) i_update (
    .base_i    (base_i),
    .off_i     (off_s),
    .mod_i     (mod_i),
    .circ_i    (circ),
    .mask_i    (mask),
    .addr_o    (addr_d),
    .base_new_o(base_d),
    .wb_o      (wb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      wb_en_o    <= 1'b0;
      addr_o     <= '0;
      base_new_o <= '0;
    end else begin
      valid_o <= req_i;
      wb_en_o <= req_i & wb_d;
      if (req_i) begin
        addr_o     <= addr_d;
        base_new_o <= base_d;
      end
    end
  end
endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [2:0]    mod_i,
  input logic [AW-1:0] base_i,
  input logic          valid_o,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] base_new_o,
  input logic          wb_en_o
);
  a_r9_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(req_i));

  a_r9_wb_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o);

  a_r3_offset_forms_keep_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mod_i) <= 3'd1 || $past(mod_i) >= 3'd6))
      |-> (!wb_en_o && base_new_o == $past(base_i)));

  a_r4_pre_access_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mod_i) == 3'd2 || $past(mod_i) == 3'd3))
      |-> (wb_en_o && addr_o == base_new_o));

  a_r5_post_access_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mod_i) == 3'd4 || $past(mod_i) == 3'd5))
      |-> (wb_en_o && addr_o == $past(base_i)));
endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW)) i_dsp_agu_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .mod_i     (mod_i),
  .base_i    (base_i),
  .valid_o   (valid_o),
  .addr_o    (addr_o),
  .base_new_o(base_new_o),
  .wb_en_o   (wb_en_o)
);

// File: tb/test_dsp_agu.sv
module test_dsp_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        side_i = 1'b0;
  logic [3:0]  base_idx_i = '0;
  logic [31:0] base_i = '0;
  logic        off_sel_i = 1'b0;
  logic [31:0] off_reg_i = '0;
  logic [4:0]  off_imm_i = '0;
  logic [1:0]  size_i = '0;
  logic [2:0]  mod_i = '0;
  logic [15:0] cfg_mode_i = '0;
  logic [4:0]  cfg_bk0_i = '0;
  logic [4:0]  cfg_bk1_i = '0;
  logic        valid_o, wb_en_o;
  logic [31:0] addr_o, base_new_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dsp_agu i_dsp_agu (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .side_i(side_i),
    .base_idx_i(base_idx_i), .base_i(base_i), .off_sel_i(off_sel_i),
    .off_reg_i(off_reg_i), .off_imm_i(off_imm_i), .size_i(size_i),
    .mod_i(mod_i), .cfg_mode_i(cfg_mode_i), .cfg_bk0_i(cfg_bk0_i),
    .cfg_bk1_i(cfg_bk1_i), .valid_o(valid_o), .addr_o(addr_o),
    .base_new_o(base_new_o), .wb_en_o(wb_en_o)
  );

  // independent modulo model
  task automatic ref_model(output logic [31:0] ea, output logic [31:0] nb, output logic wb);
    longint unsigned off, blk, lo, hi, lo2, upd, b;
    int fld;
    bit dec;
    b   = longint'(base_i);
    off = off_sel_i ? longint'(off_reg_i) : longint'(off_imm_i);
    off = (off << size_i) & 64'hFFFF_FFFF;
    blk = 64'h1_0000_0000;
    if (base_idx_i >= 4 && base_idx_i <= 7) begin
      fld = int'((cfg_mode_i >> (2 * (4 * int'(side_i) + int'(base_idx_i) - 4))) & 16'h3);
      if (fld == 1) blk = 64'd1 << (cfg_bk0_i + 1);
      if (fld == 2) blk = 64'd1 << (cfg_bk1_i + 1);
    end
    dec = (mod_i == 3'd1) || (mod_i == 3'd3) || (mod_i == 3'd5);
    lo  = b % blk;
    hi  = b - lo;
    lo2 = dec ? (lo + blk - (off % blk)) % blk : (lo + off) % blk;
    upd = hi + lo2;
    case (mod_i)
      3'd2, 3'd3: begin ea = upd[31:0]; nb = upd[31:0]; wb = 1'b1; end
      3'd4, 3'd5: begin ea = base_i;    nb = upd[31:0]; wb = 1'b1; end
      default:    begin ea = upd[31:0]; nb = base_i;    wb = 1'b0; end
    endcase
  endtask

  task automatic check(input string tag, input logic v, input logic [31:0] ea,
                       input logic [31:0] nb, input logic wb);
    n_chk++;
    if (valid_o !== v || addr_o !== ea || base_new_o !== nb || wb_en_o !== wb) begin
      n_fail++;
      $display("FAIL %s: got v=%0b addr=%h nb=%h wb=%0b exp v=%0b addr=%h nb=%h wb=%0b",
               tag, valid_o, addr_o, base_new_o, wb_en_o, v, ea, nb, wb);
    end
  endtask

  task automatic drive(input logic sd, input logic [3:0] idx, input logic [31:0] b,
                       input logic sel, input logic [31:0] oreg, input logic [4:0] imm,
                       input logic [1:0] sz, input logic [2:0] md);
    req_i = 1'b1; side_i = sd; base_idx_i = idx; base_i = b; off_sel_i = sel;
    off_reg_i = oreg; off_imm_i = imm; size_i = sz; mod_i = md;
  endtask

  task automatic dir(input string tag, input logic sd, input logic [3:0] idx,
                     input logic [31:0] b, input logic sel, input logic [31:0] oreg,
                     input logic [4:0] imm, input logic [1:0] sz, input logic [2:0] md,
                     input logic [31:0] ea, input logic [31:0] nb, input logic wb);
    drive(sd, idx, b, sel, oreg, imm, sz, md);
    @(negedge clk_i);
    check(tag, 1'b1, ea, nb, wb);
  endtask

  initial begin
    logic [31:0] ea, nb;
    logic wb;
    void'($urandom(32'h5EED_0A61));
    repeat (3) @(negedge clk_i);
    check("R10 reset", 1'b0, 32'h0, 32'h0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // A4: circ bk0, A6: code 11, B5: circ bk1
    cfg_mode_i = 16'h0831;
    cfg_bk0_i = 5'd3;  // 16 bytes
    cfg_bk1_i = 5'd2;  // 8 bytes

    dir("R1 reg offset R2 dword", 0, 0, 32'h1000, 1, 32'd3, 5'd0, 2'd3, 3'd0, 32'h1018, 32'h1000, 0);
    dir("R1 imm offset R2 byte",  0, 0, 32'h1000, 0, 32'hFFFF, 5'd31, 2'd0, 3'd0, 32'h101F, 32'h1000, 0);
    dir("R2 half R3 neg",         0, 1, 32'h1000, 0, 32'd0, 5'd5, 2'd1, 3'd1, 32'h0FF6, 32'h1000, 0);
    dir("R2 reg truncation",      0, 1, 32'h0, 1, 32'h2000_0001, 5'd0, 2'd3, 3'd0, 32'h8, 32'h0, 0);
    dir("R4 pre-inc",             1, 1, 32'h2000, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h2008, 32'h2008, 1);
    dir("R4 pre-dec",             1, 1, 32'h2000, 0, 32'd0, 5'd2, 2'd2, 3'd3, 32'h1FF8, 32'h1FF8, 1);
    dir("R5 post-inc",            0, 2, 32'h2000, 0, 32'd0, 5'd2, 2'd2, 3'd4, 32'h2000, 32'h2008, 1);
    dir("R5 post-dec",            0, 2, 32'h2000, 0, 32'd0, 5'd2, 2'd2, 3'd5, 32'h2000, 32'h1FF8, 1);
    dir("R3 code 6 as positive",  0, 2, 32'h2000, 0, 32'd0, 5'd2, 2'd2, 3'd6, 32'h2008, 32'h2000, 0);
    dir("R3 code 7 as positive",  0, 2, 32'h2000, 0, 32'd0, 5'd1, 2'd0, 3'd7, 32'h2001, 32'h2000, 0);
    dir("R8 circ wrap up",        0, 4, 32'h100C, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h1004, 32'h1004, 1);
    dir("R8 circ wrap down",      0, 4, 32'h1000, 0, 32'd0, 5'd1, 2'd2, 3'd5, 32'h1000, 32'h100C, 1);
    dir("R8 circ neg offset",     0, 4, 32'h1004, 0, 32'd0, 5'd3, 2'd2, 3'd1, 32'h1008, 32'h1004, 0);
    dir("R7 bk1 select",          1, 5, 32'h3006, 0, 32'd0, 5'd5, 2'd0, 3'd0, 32'h3003, 32'h3006, 0);
    dir("R7 code 11 linear",      0, 6, 32'h100C, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h1014, 32'h1014, 1);
    dir("R7 side selects field",  1, 4, 32'h100C, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h1014, 32'h1014, 1);
    cfg_mode_i = 16'hFFFF & 16'h5555;  // every eligible register circ bk0
    dir("R6 idx3 linear",         0, 3, 32'h100C, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h1014, 32'h1014, 1);
    dir("R6 idx8 linear",         1, 8, 32'h100C, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h1014, 32'h1014, 1);
    dir("R6 idx7 circular",       1, 7, 32'h100C, 0, 32'd0, 5'd2, 2'd2, 3'd2, 32'h1004, 32'h1004, 1);
    cfg_bk0_i = 5'd31;
    dir("R8 full range block",    0, 4, 32'hFFFF_FFFC, 0, 32'd0, 5'd1, 2'd2, 3'd4, 32'hFFFF_FFFC, 32'h0, 1);
    cfg_bk0_i = 5'd0;
    dir("R8 2-byte block",        0, 5, 32'h1001, 0, 32'd0, 5'd1, 2'd0, 3'd2, 32'h1000, 32'h1000, 1);

    req_i = 1'b0;
    mod_i = 3'd2;
    @(negedge clk_i);
    check("R9 idle no valid", 1'b0, 32'h1000, 32'h1000, 1'b0);

    // R9 back-to-back latency is implicit in every random vector
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) begin
        cfg_mode_i = 16'($urandom);
        cfg_bk0_i  = 5'($urandom);
        cfg_bk1_i  = 5'($urandom);
      end
      drive(1'($urandom), 4'($urandom), $urandom, 1'($urandom), $urandom,
            5'($urandom), 2'($urandom), 3'($urandom));
      if ($urandom % 3 == 0) base_idx_i = 4'(4 + $urandom % 4);
      if ($urandom % 4 == 0) off_reg_i = $urandom % 64;
      req_i = ($urandom % 8) != 0;
      ref_model(ea, nb, wb);
      begin
        logic r;
        r = req_i;
        @(negedge clk_i);
        if (r) check("rand R1 R2 R3 R4 R5 R6 R7 R8", 1'b1, ea, nb, wb);
        else begin
          n_chk++;
          if (valid_o !== 1'b0 || wb_en_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 idle: got v=%0b wb=%0b exp v=0 wb=0", valid_o, wb_en_o);
          end
        end
      end
    end

    req_i = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule